// File: doc/BRIEF.md
# Multi-Channel Wiper Position Register Bank

This block stores the tap positions for a set of independent 256-step tap selectors. Each channel keeps one live position register, called the wiper, and a small set of stored data registers. A host-side command port, fed by a separate serial slave front end, can read or write any register. It can also load a channel's wiper from one of its stored registers, or save the wiper into one of them.

Each wiper value drives a decoder that produces a strictly one-hot switch-enable vector for that channel. The decoder output changes on the same clock edge as the wiper register, because it is a purely combinational decode of that register.

Any command that writes a stored register raises a one-cycle request pulse. The front end uses this pulse to start its nonvolatile-write busy timer. At reset, every stored register takes a parameter default. Each wiper takes the reset value of stored register 0 of its own channel.

Top module: `wiper_bank`

## Requirements
- R1: While `rst_n` is low, and after it is released with no command applied, every stored register reads `DEF_DATA` (default 8'h80). Every wiper equals `DEF_DATA`, the value of its channel's stored register 0. `rd_valid` and `nv_req` are low.
- R2: A command with `cmd_op` = 3'b001 (write wiper) sets the wiper of channel `cmd_chan` to `cmd_wdata` at the clock edge that samples it, and the tap output changes at that same edge.
- R3: A command with `cmd_op` = 3'b011 (write stored) writes `cmd_wdata` into stored register `cmd_reg` of channel `cmd_chan`, and `nv_req` is high for the one cycle after that edge.
- R4: A command with `cmd_op` = 3'b000 (read wiper) or 3'b010 (read stored register `cmd_reg`) presents the value on `rd_data` with `rd_valid` high in the cycle after the sampling edge.
- R5: A command with `cmd_op` = 3'b100 (transfer) copies stored register `cmd_reg` of channel `cmd_chan` into that channel's wiper in one clock cycle.
- R6: A command with `cmd_op` = 3'b101 (save) copies the wiper of channel `cmd_chan` into its stored register `cmd_reg`, and pulses `nv_req` for one cycle.
- R7: For every channel c, `tap_en[c*256 +: 256]` has exactly one bit set, at bit index equal to that channel's wiper value.
- R8: Codes 3'b110 and 3'b111, any command with `cmd_valid` low, and any command on another channel change no register of a channel. Reserved codes and idle cycles raise neither `rd_valid` nor `nv_req`.
- R9: `nv_req` is high only in the cycle after a write-stored or save command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_chan | input | 2 | Channel index |
| cmd_reg | input | 2 | Stored register index |
| cmd_op | input | 3 | Operation code |
| cmd_wdata | input | 8 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read data |
| nv_req | output | 1 | Nonvolatile write request pulse |
| tap_en | output | 1024 | One-hot switch enables, channel c at bits c*256+position |

## Verification
The assertions assume that every command field is settled at the sampling clock edge. They also assume reset is held across at least one edge, and that channel and register indices always name an existing register, which holds because both counts are powers of two. The bench changes inputs only on the falling edge and issues one command, then an idle cycle, so each response is attributed to a single command. The reserved codes are driven with a nonzero data word, to show that the data is ignored.

// File: rtl/wiper_bank_pkg.sv
// Shared operation codes for the wiper register bank.
// Assumes a 3-bit opcode field on the host command port.
package wiper_bank_pkg;
    typedef enum logic [2:0] {
        OP_RD_WIPER = 3'd0,
        OP_WR_WIPER = 3'd1,
        OP_RD_DATA  = 3'd2,
        OP_WR_DATA  = 3'd3,
        OP_XFER     = 3'd4,
        OP_SAVE     = 3'd5,
        OP_RSV6     = 3'd6,
        OP_RSV7     = 3'd7
    } op_e;
endpackage

// File: rtl/wiper_chan_regs.sv
// One channel: a wiper register plus NDREG stored registers.
// Executes write, transfer and save when selected. Exposes the wiper and
// the stored register addressed by reg_idx. Assumes sel is already qualified
// by cmd_valid and the channel match.
module wiper_chan_regs
    import wiper_bank_pkg::*;
#(
    parameter int WW    = 8,
    parameter int NDREG = 4,
    parameter logic [WW-1:0] DEF_DATA = 'h80,
    localparam int RW = $clog2(NDREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  op_e           op,
    input  logic [RW-1:0] reg_idx,
    input  logic [WW-1:0] wdata,
    output logic [WW-1:0] wiper,
    output logic [WW-1:0] dval
);
    logic [WW-1:0] store_q [NDREG];

    // Register update: reset defaults, then the selected command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NDREG; i++) store_q[i] <= DEF_DATA;
            wiper <= DEF_DATA;  // same as the reset value of stored register 0
        end else if (sel) begin
            case (op)
                OP_WR_WIPER: wiper <= wdata;
                OP_WR_DATA:  store_q[reg_idx] <= wdata;
                OP_XFER:     wiper <= store_q[reg_idx];
                OP_SAVE:     store_q[reg_idx] <= wiper;
                default: ;
            endcase
        end
    end

    // Read path for the addressed stored register.
    assign dval = store_q[reg_idx];
endmodule

// File: rtl/wiper_tap_decode.sv
// Decodes a WW-bit position into a 2**WW one-hot enable vector.
// Purely combinational, so it follows the wiper register on the same edge.
module wiper_tap_decode #(
    parameter int WW = 8,
    localparam int NTAP = 1 << WW
) (
    input  logic [WW-1:0]   code,
    output logic [NTAP-1:0] onehot
);
    // One comparator per tap position.
    for (genvar t = 0; t < NTAP; t++) begin : g_tap
        assign onehot[t] = (code == WW'(t));
    end
endmodule

// File: rtl/wiper_bank.sv
// Top of the wiper register bank: NCH channels of position and stored
// registers, a one-hot decoder per channel, and a registered host response.
// Assumes one command per cycle from the serial front end.
module wiper_bank
    import wiper_bank_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int NDREG = 4,
    parameter int WW    = 8,
    parameter logic [WW-1:0] DEF_DATA = 'h80,
    localparam int CHW  = $clog2(NCH),
    localparam int RW   = $clog2(NDREG),
    localparam int NTAP = 1 << WW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic [CHW-1:0]      cmd_chan,
    input  logic [RW-1:0]       cmd_reg,
    input  logic [2:0]          cmd_op,
    input  logic [WW-1:0]       cmd_wdata,
    output logic                rd_valid,
    output logic [WW-1:0]       rd_data,
    output logic                nv_req,
    output logic [NCH*NTAP-1:0] tap_en
);
    op_e           op;
    logic [WW-1:0] wiper_w [NCH];
    logic [WW-1:0] dval_w  [NCH];
    logic          is_read;
    logic          is_store;

    assign op = op_e'(cmd_op);

    // One register set and decoder per channel.
    for (genvar g = 0; g < NCH; g++) begin : g_chan
        wiper_chan_regs #(
            .WW(WW), .NDREG(NDREG), .DEF_DATA(DEF_DATA)
        ) regs_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .sel     (cmd_valid && (cmd_chan == CHW'(g))),
            .op      (op),
            .reg_idx (cmd_reg),
            .wdata   (cmd_wdata),
            .wiper   (wiper_w[g]),
            .dval    (dval_w[g])
        );

        wiper_tap_decode #(.WW(WW)) dec_i (
            .code   (wiper_w[g]),
            .onehot (tap_en[g*NTAP +: NTAP])
        );
    end

    // Command class flags for the response stage.
    assign is_read  = cmd_valid && (op == OP_RD_WIPER || op == OP_RD_DATA);
    assign is_store = cmd_valid && (op == OP_WR_DATA || op == OP_SAVE);

    // Registered read response and nonvolatile write request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            nv_req   <= 1'b0;
        end else begin
            rd_valid <= is_read;
            nv_req   <= is_store;
            if (is_read)
                rd_data <= (op == OP_RD_WIPER) ? wiper_w[cmd_chan] : dval_w[cmd_chan];
        end
    end
endmodule

// File: rtl/wiper_bank_chk.sv
// Assertion checker for wiper_bank, attached with bind below.
// Observes ports only; assumes inputs are stable around the clock edge.
module wiper_bank_chk #(
    parameter int NCH  = 4,
    parameter int WW   = 8,
    parameter int CHW  = 2,
    parameter int RW   = 2,
    parameter int NTAP = 256
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cmd_valid,
    input logic [CHW-1:0]      cmd_chan,
    input logic [RW-1:0]       cmd_reg,
    input logic [2:0]          cmd_op,
    input logic [WW-1:0]       cmd_wdata,
    input logic                rd_valid,
    input logic [WW-1:0]       rd_data,
    input logic                nv_req,
    input logic [NCH*NTAP-1:0] tap_en
);
    logic rd_cmd, st_cmd, wr_wip;

    // Command classification seen at the ports.
    always_comb begin
        rd_cmd = cmd_valid && (cmd_op == 3'd0 || cmd_op == 3'd2);
        st_cmd = cmd_valid && (cmd_op == 3'd3 || cmd_op == 3'd5);
        wr_wip = cmd_valid && (cmd_op == 3'd1);
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        AST_TAP_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(tap_en[g*NTAP +: NTAP]) == 1); // R7
        AST_OTHER_CHAN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
            (!cmd_valid || cmd_chan != CHW'(g)) |=> $stable(tap_en[g*NTAP +: NTAP])); // R8
    end

    AST_WR_WIPER_TAP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_wip |=> tap_en[{$past(cmd_chan), $past(cmd_wdata)}]); // R2
    AST_STORE_NV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        st_cmd |=> nv_req); // R3
    AST_NV_ONLY_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        !st_cmd |=> !nv_req); // R9
    AST_READ_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cmd |=> rd_valid); // R4
    AST_NO_SPURIOUS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_cmd |=> !rd_valid); // R8
    AST_RD_WIPER_POS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd0) |=> tap_en[{$past(cmd_chan), rd_data}]); // R4
endmodule

bind wiper_bank wiper_bank_chk #(
    .NCH(NCH), .WW(WW), .CHW(CHW), .RW(RW), .NTAP(NTAP)
) chk_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_chan(cmd_chan),
    .cmd_reg(cmd_reg), .cmd_op(cmd_op), .cmd_wdata(cmd_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .nv_req(nv_req), .tap_en(tap_en)
);

// File: tb/wiper_bank_tb_top.sv
// Self-checking bench: vector table walk, then directed reset and idle tests.
module wiper_bank_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_valid = 1'b0;
    logic [1:0]   cmd_chan = '0;
    logic [1:0]   cmd_reg = '0;
    logic [2:0]   cmd_op = '0;
    logic [7:0]   cmd_wdata = '0;
    logic         rd_valid;
    logic [7:0]   rd_data;
    logic         nv_req;
    logic [1023:0] tap_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] exp_wip [4];
    logic [7:0] exp_dat [4][4];

    always #2 clk = ~clk;  // 250 MHz

    wiper_bank dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_chan(cmd_chan),
        .cmd_reg(cmd_reg), .cmd_op(cmd_op), .cmd_wdata(cmd_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .nv_req(nv_req), .tap_en(tap_en)
    );

    typedef struct packed {
        logic [2:0] op;
        logic [1:0] ch;
        logic [1:0] rg;
        logic [7:0] wd;
        logic       rdv;
        logic [7:0] rd;
        logic       nv;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{3'd1, 2'd1, 2'd0, 8'h00, 1'b0, 8'h00, 1'b0},  // R2 write wiper c1 = 00
        '{3'd0, 2'd1, 2'd0, 8'h00, 1'b1, 8'h00, 1'b0},  // R4 read wiper c1
        '{3'd3, 2'd2, 2'd3, 8'hFF, 1'b0, 8'h00, 1'b1},  // R3 write stored c2 r3
        '{3'd4, 2'd2, 2'd3, 8'h00, 1'b0, 8'h00, 1'b0},  // R5 transfer c2 r3
        '{3'd0, 2'd2, 2'd0, 8'h00, 1'b1, 8'hFF, 1'b0},  // R5 read wiper c2
        '{3'd2, 2'd0, 2'd2, 8'h00, 1'b1, 8'h80, 1'b0},  // R1 default stored
        '{3'd5, 2'd1, 2'd1, 8'h00, 1'b0, 8'h00, 1'b1},  // R6 save c1 -> r1
        '{3'd2, 2'd1, 2'd1, 8'h00, 1'b1, 8'h00, 1'b0},  // R6 read back
        '{3'd6, 2'd1, 2'd1, 8'h55, 1'b0, 8'h00, 1'b0},  // R8 reserved
        '{3'd0, 2'd1, 2'd0, 8'h00, 1'b1, 8'h00, 1'b0},  // R8 wiper unchanged
        '{3'd7, 2'd1, 2'd1, 8'hAA, 1'b0, 8'h00, 1'b0},  // R8 reserved
        '{3'd1, 2'd3, 2'd0, 8'h7F, 1'b0, 8'h00, 1'b0},  // R2 write wiper c3
        '{3'd0, 2'd0, 2'd0, 8'h00, 1'b1, 8'h80, 1'b0},  // R8 c0 isolated
        '{3'd3, 2'd0, 2'd0, 8'h11, 1'b0, 8'h00, 1'b1},  // R3 write stored c0 r0
        '{3'd4, 2'd0, 2'd0, 8'h00, 1'b0, 8'h00, 1'b0},  // R5 transfer c0 r0
        '{3'd0, 2'd0, 2'd0, 8'h00, 1'b1, 8'h11, 1'b0}   // R5 read wiper c0
    };

    task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < 4; c++) begin
            exp_wip[c] = 8'h80;
            for (int r = 0; r < 4; r++) exp_dat[c][r] = 8'h80;
        end
    endtask

    task automatic check_taps();
        for (int c = 0; c < 4; c++)
            chk("R7 tap one-hot", tap_en[c*256 +: 256], 256'b1 << exp_wip[c]);
    endtask

    // Apply one command on a falling edge and sample one full cycle later.
    task automatic issue(input logic v, input logic [2:0] op, input logic [1:0] ch,
                         input logic [1:0] rg, input logic [7:0] wd);
        @(negedge clk);
        cmd_valid = v; cmd_op = op; cmd_chan = ch; cmd_reg = rg; cmd_wdata = wd;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (v) begin
            case (op)
                3'd1: exp_wip[ch] = wd;
                3'd3: exp_dat[ch][rg] = wd;
                3'd4: exp_wip[ch] = exp_dat[ch][rg];
                3'd5: exp_dat[ch][rg] = exp_wip[ch];
                default: ;
            endcase
        end
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        // R1: during reset
        chk("R1 rd_valid in reset", 256'(rd_valid), 256'd0);
        chk("R1 nv_req in reset", 256'(nv_req), 256'd0);
        check_taps();
        rst_n = 1'b1;

        // R8: idle cycle with a write-wiper pattern on the other fields
        issue(1'b0, 3'd1, 2'd0, 2'd0, 8'h05);
        chk("R8 idle rd_valid", 256'(rd_valid), 256'd0);
        chk("R8 idle nv_req", 256'(nv_req), 256'd0);
        check_taps();

        for (int i = 0; i < NV; i++) begin
            issue(1'b1, VECS[i].op, VECS[i].ch, VECS[i].rg, VECS[i].wd);
            chk("R4 rd_valid", 256'(rd_valid), 256'(VECS[i].rdv));
            if (VECS[i].rdv) chk("R4 rd_data", 256'(rd_data), 256'(VECS[i].rd));
            chk("R9 nv_req", 256'(nv_req), 256'(VECS[i].nv));
            check_taps();
            @(negedge clk);
            chk("R3 nv_req one cycle", 256'(nv_req), 256'd0);
        end

        // R1: reset in mid-run restores defaults
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        check_taps();
        issue(1'b1, 3'd2, 2'd1, 2'd1, 8'h00);
        chk("R1 stored reg after reset", 256'(rd_data), 256'h80);
        issue(1'b1, 3'd0, 2'd3, 2'd0, 8'h00);
        chk("R1 wiper after reset", 256'(rd_data), 256'h80);

        // R2/R7: extreme position 0xFF on channel 0
        issue(1'b1, 3'd1, 2'd0, 2'd0, 8'hFF);
        check_taps();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule